// File: doc/BRIEF.md
# Four-Way Branch Microcode Sequencer

This block is the control sequencer of a small accumulator machine. It is built around a 16-word constant microcode table. The table is addressed by a 4-bit state register. Each 40-bit microword holds three fields:

- 22 control strobes for the datapath.
- Two select bits, one for each of two condition multiplexers.
- Four explicit successor states.

The select bits stored in the word choose what the two multiplexers test. One multiplexer tests either the memory wait line or instruction bit 15. The other tests either the accumulator sign or instruction bit 14. The two chosen bits, taken as a 2-bit index, pick which successor is loaded on the next clock edge.

The control strobes are registered together with the state. The datapath therefore sees a glitch-free word that belongs to the state now held. A synchronous reset returns the machine to the reset state. The microcode walks these phases:

- A fetch phase with memory handshake waits.
- A four-way opcode decode.
- Load, store and add sequences that each wait on memory.
- A conditional branch on the accumulator sign.

Top module: `quadBranchSequencer`

## Requirements
- R1: While `rst` is 1 at a rising clock edge, the state becomes 0 and `ctrlOut` becomes 22'h000001 after that edge, whatever the other inputs are.
- R2: The first condition bit (alpha) is `memWait` when the word's alpha select is 0, and `irBit15` when it is 1. The second condition bit (beta) is `acSign` when its select is 0, and `irBit14` when it is 1. The successor loaded is field number {alpha, beta}: alpha is the high bit, and field 0 is chosen by index 00.
- R3: In decode state 5, both selects are 1. {irBit15, irBit14} = 00, 01, 10 and 11 lead to states 6, 9, 11 and 14 respectively. `memWait` has no effect in this state.
- R4: Fetch waits:
  - State 2 moves to state 3 only when `memWait` is 1, and otherwise stays in state 2.
  - State 3 moves to state 4 only when `memWait` is 0, and otherwise stays in state 3.
  - State 4 moves to state 5 only when `memWait` is 1, and otherwise stays in state 4.
- R5: Some states advance unconditionally: state 0 goes to 1, 1 to 2, 6 to 7, 9 to 10 and 11 to 12. States 8, 13 and 15 go to state 1.
- R6: Execute memory waits:
  - State 7 stays while `memWait` is 1 and goes to state 8 when it is 0.
  - State 10 stays while `memWait` is 1 and goes to state 1 when it is 0.
  - State 12 stays while `memWait` is 1 and goes to state 13 when it is 0.
- R7: Branch state 14 goes to state 15 when `acSign` is 1 and to state 1 when it is 0. The wait and instruction bits have no effect there.
- R8: `ctrlOut` and `stateOut` change only at rising clock edges. Input changes between edges leave both unchanged.
- R9: `ctrlOut` is the control word of the state shown on `stateOut`, with these values:

  | State | `ctrlOut` |
  |---|---|
  | 0 | 22'h000001 |
  | 1 | 22'h000016 |
  | 2 | 22'h000700 |
  | 3 | 22'h000F00 |
  | 4 | 22'h0000C0 |
  | 5 | 22'h000030 |
  | 8 | 22'h398000 |
  | 9 | 22'h006000 |
  | 10 | 22'h001300 |
  | 13 | 22'h378000 |
  | 14 | 22'h000000 |
  | 15 | 22'h000028 |

- R10: The memory request strobe (bit 9) is never high unless the address-drive strobe (bit 8) is also high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| memWait | input | 1 | Memory handshake wait line |
| irBit15 | input | 1 | Instruction register bit 15 (opcode high bit) |
| irBit14 | input | 1 | Instruction register bit 14 (opcode low bit) |
| acSign | input | 1 | Accumulator sign bit |
| stateOut | output | 4 | Current sequencer state |
| ctrlOut | output | 22 | Registered control strobes of the current state |

## Verification
The four-way decode and the sign branch are the hardest places to reach. The ports cannot load a state directly. The only way in is to walk the whole fetch handshake, steering `memWait` high, then low, then high at exactly the right cycles. Each scenario task therefore starts with a shared fetch walk that stops in the decode state. It then applies one opcode pattern, holding the wait line at the level that would have moved a wait state. This shows that the wait line is ignored in decode. The branch test reaches state 14 twice. Each time it sets the wait and opcode bits to the values most likely to mislead a wrong multiplexer select.

// File: rtl/qbsPkg.sv
package qbsPkg;
  localparam int STATE_W = 4;
  localparam int FANOUT  = 4;
  localparam int NUM_WORDS = 1 << STATE_W;
  localparam int SEL_W   = $clog2(FANOUT);

  // Control strobes; the first member is the MSB (bit 21), pcClear is bit 0.
  typedef struct packed {
    logic rbusToAc;    // 21
    logic aluToRbus;   // 20
    logic aluPassB;    // 19
    logic aluAdd;      // 18
    logic acToAluA;    // 17
    logic mbusToAluB;  // 16
    logic mbrToMbus;   // 15
    logic rbusToMbr;   // 14
    logic acToRbus;    // 13
    logic mbrToData;   // 12
    logic dataToMbr;   // 11
    logic memRead;     // 10
    logic memReq;      // 9
    logic marToAddr;   // 8
    logic mbrToAbus;   // 7
    logic abusToIr;    // 6
    logic irToAbus;    // 5
    logic abusToMar;   // 4
    logic abusToPc;    // 3
    logic pcToAbus;    // 2
    logic pcIncr;      // 1
    logic pcClear;     // 0
  } strobes_t;

  localparam int CTRL_W = $bits(strobes_t);

  typedef logic [STATE_W-1:0] state_t;

  typedef struct packed {
    state_t [FANOUT-1:0] succ;
    logic                selAlpha;
    logic                selBeta;
    strobes_t            ctrl;
  } word_t;
endpackage

// File: rtl/qbsWordRom.sv
module qbsWordRom
  import qbsPkg::*;
(
  input  state_t addr,
  output word_t  word
);
  function automatic word_t mkWord(strobes_t c, logic sa, logic sb,
                                   state_t n0, state_t n1, state_t n2, state_t n3);
    word_t w;
    w.ctrl     = c;
    w.selAlpha = sa;
    w.selBeta  = sb;
    w.succ[0]  = n0;
    w.succ[1]  = n1;
    w.succ[2]  = n2;
    w.succ[3]  = n3;
    return w;
  endfunction

  always_comb begin
    strobes_t s;
    s = '0;
    word = mkWord('0, 1'b0, 1'b0, 4'd1, 4'd1, 4'd1, 4'd1);
    unique case (addr)
      4'd0: begin s.pcClear = 1'b1; word = mkWord(s, 1'b0, 1'b0, 4'd1, 4'd1, 4'd1, 4'd1); end
      4'd1: begin
        s.pcToAbus = 1'b1; s.abusToMar = 1'b1; s.pcIncr = 1'b1;
        word = mkWord(s, 1'b0, 1'b0, 4'd2, 4'd2, 4'd2, 4'd2);
      end
      4'd2: begin
        s.marToAddr = 1'b1; s.memReq = 1'b1; s.memRead = 1'b1;
        word = mkWord(s, 1'b0, 1'b0, 4'd2, 4'd2, 4'd3, 4'd3);
      end
      4'd3: begin
        s.marToAddr = 1'b1; s.memReq = 1'b1; s.memRead = 1'b1; s.dataToMbr = 1'b1;
        word = mkWord(s, 1'b0, 1'b0, 4'd4, 4'd4, 4'd3, 4'd3);
      end
      4'd4: begin
        s.mbrToAbus = 1'b1; s.abusToIr = 1'b1;
        word = mkWord(s, 1'b0, 1'b0, 4'd4, 4'd4, 4'd5, 4'd5);
      end
      4'd5: begin
        s.irToAbus = 1'b1; s.abusToMar = 1'b1;
        word = mkWord(s, 1'b1, 1'b1, 4'd6, 4'd9, 4'd11, 4'd14);
      end
      4'd6, 4'd11: begin
        s.marToAddr = 1'b1; s.memReq = 1'b1; s.memRead = 1'b1;
        word = mkWord(s, 1'b0, 1'b0, addr + 4'd1, addr + 4'd1, addr + 4'd1, addr + 4'd1);
      end
      4'd7, 4'd12: begin
        s.marToAddr = 1'b1; s.memReq = 1'b1; s.memRead = 1'b1; s.dataToMbr = 1'b1;
        word = mkWord(s, 1'b0, 1'b0, addr + 4'd1, addr + 4'd1, addr, addr);
      end
      4'd8: begin
        s.mbrToMbus = 1'b1; s.mbusToAluB = 1'b1; s.aluPassB = 1'b1;
        s.aluToRbus = 1'b1; s.rbusToAc = 1'b1;
        word = mkWord(s, 1'b0, 1'b0, 4'd1, 4'd1, 4'd1, 4'd1);
      end
      4'd9: begin
        s.acToRbus = 1'b1; s.rbusToMbr = 1'b1;
        word = mkWord(s, 1'b0, 1'b0, 4'd10, 4'd10, 4'd10, 4'd10);
      end
      4'd10: begin
        s.marToAddr = 1'b1; s.memReq = 1'b1; s.mbrToData = 1'b1;
        word = mkWord(s, 1'b0, 1'b0, 4'd1, 4'd1, 4'd10, 4'd10);
      end
      4'd13: begin
        s.acToAluA = 1'b1; s.mbrToMbus = 1'b1; s.mbusToAluB = 1'b1;
        s.aluAdd = 1'b1; s.aluToRbus = 1'b1; s.rbusToAc = 1'b1;
        word = mkWord(s, 1'b0, 1'b0, 4'd1, 4'd1, 4'd1, 4'd1);
      end
      4'd14: word = mkWord(s, 1'b0, 1'b0, 4'd1, 4'd15, 4'd1, 4'd15);
      4'd15: begin
        s.irToAbus = 1'b1; s.abusToPc = 1'b1;
        word = mkWord(s, 1'b0, 1'b0, 4'd1, 4'd1, 4'd1, 4'd1);
      end
      default: word = mkWord('0, 1'b0, 1'b0, 4'd0, 4'd0, 4'd0, 4'd0);
    endcase
  end
endmodule

// File: rtl/qbsBranchPick.sv
module qbsBranchPick
  import qbsPkg::*;
(
  input  word_t  word,
  input  logic   memWait,
  input  logic   irBit15,
  input  logic   irBit14,
  input  logic   acSign,
  output state_t succ
);
  logic alpha;
  logic beta;
  logic [SEL_W-1:0] pick;

  assign alpha = word.selAlpha ? irBit15 : memWait;
  assign beta  = word.selBeta  ? irBit14 : acSign;
  assign pick  = {alpha, beta};
  assign succ  = word.succ[pick];
endmodule

// File: rtl/qbsStateReg.sv
module qbsStateReg
  import qbsPkg::*;
(
  input  logic     clk,
  input  state_t   loadState,
  input  strobes_t loadCtrl,
  output state_t   stateQ,
  output strobes_t ctrlQ
);
  always_ff @(posedge clk) begin
    stateQ <= loadState;
    ctrlQ  <= loadCtrl;
  end
endmodule

// File: rtl/quadBranchSequencer.sv
module quadBranchSequencer
  import qbsPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              memWait,
  input  logic              irBit15,
  input  logic              irBit14,
  input  logic              acSign,
  output logic [STATE_W-1:0] stateOut,
  output logic [CTRL_W-1:0]  ctrlOut
);
  state_t   curState;
  state_t   succState;
  state_t   loadState;
  word_t    curWord;
  word_t    loadWord;
  strobes_t curCtrl;

  qbsWordRom i_curRom (.addr(curState), .word(curWord));

  qbsBranchPick i_pick (
    .word(curWord), .memWait(memWait), .irBit15(irBit15),
    .irBit14(irBit14), .acSign(acSign), .succ(succState)
  );

  // Synchronous reset overrides the chosen successor.
  assign loadState = rst ? '0 : succState;

  qbsWordRom i_loadRom (.addr(loadState), .word(loadWord));

  qbsStateReg i_reg (
    .clk(clk), .loadState(loadState), .loadCtrl(loadWord.ctrl),
    .stateQ(curState), .ctrlQ(curCtrl)
  );

  assign stateOut = curState;
  assign ctrlOut  = curCtrl;
endmodule

// File: rtl/qbsChecker.sv
module qbsChecker
  import qbsPkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               memWait,
  input logic               irBit15,
  input logic               irBit14,
  input logic               acSign,
  input logic [STATE_W-1:0] stateOut,
  input logic [CTRL_W-1:0]  ctrlOut
);
  logic rstSeen;
  always_ff @(posedge clk) rstSeen <= rst;

  always @(negedge clk) begin
    if (rstSeen === 1'b1) begin
      assert_reset_R1: assert (stateOut == 4'd0 && ctrlOut == 22'h000001)
        else $error("reset did not return to state 0");
    end
  end

  assert_decode00_R3: assert property (@(posedge clk) disable iff (rst)
    (stateOut == 4'd5 && !irBit15 && !irBit14) |=> stateOut == 4'd6);

  assert_decode11_R3: assert property (@(posedge clk) disable iff (rst)
    (stateOut == 4'd5 && irBit15 && irBit14) |=> stateOut == 4'd14);

  assert_fetchHold_R4: assert property (@(posedge clk) disable iff (rst)
    (stateOut == 4'd2 && !memWait) |=> stateOut == 4'd2);

  assert_branchTaken_R7: assert property (@(posedge clk) disable iff (rst)
    (stateOut == 4'd14 && acSign) |=> stateOut == 4'd15);

  assert_memReq_R10: assert property (@(posedge clk) disable iff (rst)
    ctrlOut[9] |-> ctrlOut[8]);
endmodule

bind quadBranchSequencer qbsChecker i_chk (
  .clk(clk), .rst(rst), .memWait(memWait), .irBit15(irBit15),
  .irBit14(irBit14), .acSign(acSign), .stateOut(stateOut), .ctrlOut(ctrlOut)
);

// File: tb/test_quadBranchSequencer.sv
module test_quadBranchSequencer;
  localparam int PERIOD = 10;
  localparam int QTR = PERIOD / 4;

  logic clk = 1'b0;
  logic rst, memWait, irBit15, irBit14, acSign;
  logic [3:0]  stateOut;
  logic [21:0] ctrlOut;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  quadBranchSequencer i_quadBranchSequencer (
    .clk(clk), .rst(rst), .memWait(memWait), .irBit15(irBit15),
    .irBit14(irBit14), .acSign(acSign), .stateOut(stateOut), .ctrlOut(ctrlOut)
  );

  task automatic check(input string req, input logic [21:0] got, input logic [21:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Drive inputs a quarter period after an edge, then sample a quarter after the next edge.
  task automatic tick(input logic w, input logic i15, input logic i14, input logic a);
    memWait = w; irBit15 = i15; irBit14 = i14; acSign = a;
    @(posedge clk);
    #QTR;
  endtask

  task automatic doReset();
    rst = 1'b1;
    tick(1'b1, 1'b1, 1'b1, 1'b1);
    tick(1'b0, 1'b1, 1'b0, 1'b1);
    check("R1 reset state", {18'd0, stateOut}, 22'd0);
    check("R1/R9 reset ctrl", ctrlOut, 22'h000001);
    rst = 1'b0;
  endtask

  // Walk from state 0 to decode state 5 using the fetch handshake.
  task automatic fetchToDecode(input bit verbose);
    tick(1'b0, 1'b0, 1'b0, 1'b0);
    if (verbose) begin
      check("R5 0->1", {18'd0, stateOut}, 22'd1);
      check("R9 ctrl state1", ctrlOut, 22'h000016);
    end
    tick(1'b0, 1'b0, 1'b0, 1'b0);
    if (verbose) check("R9 ctrl state2", ctrlOut, 22'h000700);
    tick(1'b0, 1'b1, 1'b1, 1'b1);
    if (verbose) check("R4 state2 holds wait0", {18'd0, stateOut}, 22'd2);
    tick(1'b1, 1'b0, 1'b0, 1'b0);
    if (verbose) begin
      check("R4 state2->3", {18'd0, stateOut}, 22'd3);
      check("R9 ctrl state3", ctrlOut, 22'h000F00);
    end
    tick(1'b1, 1'b0, 1'b0, 1'b0);
    if (verbose) check("R4 state3 holds wait1", {18'd0, stateOut}, 22'd3);
    tick(1'b0, 1'b0, 1'b0, 1'b0);
    if (verbose) check("R4 state3->4", {18'd0, stateOut}, 22'd4);
    tick(1'b0, 1'b1, 1'b1, 1'b1);
    if (verbose) check("R4 state4 holds wait0", {18'd0, stateOut}, 22'd4);
    tick(1'b1, 1'b0, 1'b0, 1'b0);
    check("R4 reach decode", {18'd0, stateOut}, 22'd5);
    if (verbose) check("R9 ctrl state5", ctrlOut, 22'h000030);
  endtask

  task automatic testFetch();
    doReset();
    fetchToDecode(1'b1);
  endtask

  task automatic testLoad();
    tick(1'b1, 1'b0, 1'b0, 1'b1);  // decode, opcode 00, wait high ignored
    check("R3/R2 decode 00->6", {18'd0, stateOut}, 22'd6);
    tick(1'b1, 1'b1, 1'b1, 1'b1);
    check("R5 6->7", {18'd0, stateOut}, 22'd7);
    tick(1'b1, 1'b0, 1'b0, 1'b0);
    check("R6 state7 holds", {18'd0, stateOut}, 22'd7);
    tick(1'b0, 1'b0, 1'b0, 1'b0);
    check("R6 7->8", {18'd0, stateOut}, 22'd8);
    check("R9 ctrl state8", ctrlOut, 22'h398000);
    tick(1'b1, 1'b1, 1'b1, 1'b1);
    check("R5 8->1", {18'd0, stateOut}, 22'd1);
  endtask

  task automatic testStore();
    fetchToDecode(1'b0);
    tick(1'b0, 1'b0, 1'b1, 1'b0);
    check("R3/R2 decode 01->9", {18'd0, stateOut}, 22'd9);
    check("R9 ctrl state9", ctrlOut, 22'h006000);
    tick(1'b0, 1'b0, 1'b0, 1'b0);
    check("R5 9->10", {18'd0, stateOut}, 22'd10);
    check("R9 ctrl state10", ctrlOut, 22'h001300);
    tick(1'b1, 1'b0, 1'b0, 1'b0);
    check("R6 state10 holds", {18'd0, stateOut}, 22'd10);
    tick(1'b0, 1'b1, 1'b1, 1'b1);
    check("R6 10->1", {18'd0, stateOut}, 22'd1);
  endtask

  task automatic testAdd();
    fetchToDecode(1'b0);
    tick(1'b1, 1'b1, 1'b0, 1'b1);
    check("R3/R2 decode 10->11", {18'd0, stateOut}, 22'd11);
    tick(1'b0, 1'b0, 1'b0, 1'b0);
    check("R5 11->12", {18'd0, stateOut}, 22'd12);
    tick(1'b1, 1'b0, 1'b0, 1'b0);
    check("R6 state12 holds", {18'd0, stateOut}, 22'd12);
    tick(1'b0, 1'b0, 1'b0, 1'b0);
    check("R6 12->13", {18'd0, stateOut}, 22'd13);
    check("R9 ctrl state13", ctrlOut, 22'h378000);
    tick(1'b0, 1'b0, 1'b0, 1'b0);
    check("R5 13->1", {18'd0, stateOut}, 22'd1);
  endtask

  task automatic testBranch();
    fetchToDecode(1'b0);
    tick(1'b0, 1'b1, 1'b1, 1'b0);
    check("R3/R2 decode 11->14", {18'd0, stateOut}, 22'd14);
    check("R9 ctrl state14", ctrlOut, 22'h000000);
    tick(1'b1, 1'b1, 1'b1, 1'b0);  // sign clear, distractors high
    check("R7 not taken 14->1", {18'd0, stateOut}, 22'd1);
    fetchToDecode(1'b0);
    tick(1'b1, 1'b1, 1'b1, 1'b0);
    check("R3 decode 11 wait high", {18'd0, stateOut}, 22'd14);
    tick(1'b0, 1'b0, 1'b0, 1'b1);  // sign set, distractors low
    check("R7 taken 14->15", {18'd0, stateOut}, 22'd15);
    check("R9 ctrl state15", ctrlOut, 22'h000028);
    tick(1'b0, 1'b0, 1'b0, 1'b0);
    check("R5 15->1", {18'd0, stateOut}, 22'd1);
  endtask

  task automatic testStability();
    logic [21:0] ctrlSnap;
    logic [3:0]  stSnap;
    ctrlSnap = ctrlOut;
    stSnap = stateOut;
    memWait = ~memWait; irBit15 = ~irBit15; irBit14 = ~irBit14; acSign = ~acSign;
    #QTR;
    check("R8 ctrl stable between edges", ctrlOut, ctrlSnap);
    check("R8 state stable between edges", {18'd0, stateOut}, {18'd0, stSnap});
    check("R10 request implies address", {21'd0, ctrlOut[9] & ~ctrlOut[8]}, 22'd0);
  endtask

  task automatic testMidReset();
    fetchToDecode(1'b0);
    rst = 1'b1;
    tick(1'b1, 1'b1, 1'b1, 1'b1);
    check("R1 reset from decode", {18'd0, stateOut}, 22'd0);
    check("R1 reset ctrl from decode", ctrlOut, 22'h000001);
    rst = 1'b0;
  endtask

  initial begin
    #(PERIOD * 5000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; memWait = 1'b0; irBit15 = 1'b0; irBit14 = 1'b0; acSign = 1'b0;
    #QTR;
    testFetch();
    testStability();
    testLoad();
    testStore();
    testAdd();
    testBranch();
    fetchToDecode(1'b0);
    tick(1'b0, 1'b0, 1'b0, 1'b0);
    testStability();
    testMidReset();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule